// File: doc/BRIEF.md
# Balanced Ternary Increment/Decrement Chain

This block adds a single control trit of value -1, 0 or +1 to a multi-trit balanced ternary number and returns the adjusted number together with a carry-out trit. It is purely combinational: a chain of identical one-trit half-adder cells, each built from three-way trit selectors and two-way edge selectors. The control trit enters the least significant cell as its adjust input, and each cell's carry becomes the adjust input of the next, more significant cell. The carry of the top cell leaves the block.

A control trit of -1 decrements, 0 holds and +1 increments. The number of trits is a parameter (default 3). Because the carry-out is kept, the pair (carry, result) represents the exact sum over the whole input range. There is no saturation and no further flag. The block has no states: the state-machine layout of the house style reduces here to one combinational path per cell, with no state or transition to name.

Top module: `tern_incdec`

## Requirements
- R1: Each trit is two bits: 2'b00 is zero (O), 2'b01 is +1 (P), 2'b11 is -1 (N). Trit k of a vector sits in bits [2k+1:2k], and trit 0 is the least significant.
- R2: With adjust O, the result equals the input number and the carry-out is O.
- R3: With adjust P, the result plus carry-out times 3^W equals the input value plus one.
- R4: With adjust N, the result plus carry-out times 3^W equals the input value minus one.
- R5: For every legal input and adjust, carry_o*3^W + value(sum_o) equals value(num_i) + value(adj_i), where W is the width in trits.
- R6: The carry-out is P only when every input trit is P and adjust is P; the result is then all N.
- R7: The carry-out is N only when every input trit is N and adjust is N; the result is then all P.
- R8: For legal input codes, every output trit is one of the three legal codes, never 2'b10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| num_i | input | 2*WIDTH | Balanced ternary operand, trit 0 in the low bits |
| adj_i | input | 2 | Control trit: N decrements, O holds, P increments |
| sum_o | output | 2*WIDTH | Adjusted number, same layout as num_i |
| carry_o | output | 2 | Carry or borrow trit out of the top cell |

## Verification
The wrap of the result and the appearance of a nonzero carry-out happen in the same evaluation: incrementing the all-P number, or decrementing the all-N number, makes every result trit flip and the carry leave the chain at once. The sweep applies every 3^W operand with each of the three adjust values, so both extremes and every partial ripple length are reached. Each vector is judged by converting the outputs back to an integer and comparing it with the operand plus the adjust, and both wrap cases also get explicit checks on the carry and on the all-N or all-P result pattern.

// File: rtl/tern_pkg.sv
package tern_pkg;

    typedef logic [1:0] trit_t;

    localparam trit_t TR_ZERO = 2'b00;
    localparam trit_t TR_POS  = 2'b01;
    localparam trit_t TR_NEG  = 2'b11;

    function automatic int trit_val(input trit_t t);
        case (t)
            TR_POS:  return 1;
            TR_NEG:  return -1;
            default: return 0;
        endcase
    endfunction

    function automatic bit trit_legal(input trit_t t);
        return (t == TR_ZERO) || (t == TR_POS) || (t == TR_NEG);
    endfunction

    function automatic int pow3(input int n);
        int r;
        r = 1;
        for (int i = 0; i < n; i++) r = r * 3;
        return r;
    endfunction

endpackage

// File: rtl/tern_sel3.sv
module tern_sel3
    import tern_pkg::*;
(
    input  trit_t sel,
    input  trit_t on_neg,
    input  trit_t on_zero,
    input  trit_t on_pos,
    output trit_t y
);
    always_comb begin
        case (sel)
            TR_NEG:  y = on_neg;
            TR_POS:  y = on_pos;
            default: y = on_zero;
        endcase
    end
endmodule

// File: rtl/tern_edge.sv
module tern_edge
    import tern_pkg::*;
#(
    parameter bit POS_SIDE = 1'b0
)(
    input  trit_t x,
    input  trit_t a,
    input  trit_t b,
    output trit_t y
);
    generate
        if (POS_SIDE) begin : g_pos
            assign y = (x == TR_POS) ? b : a;
        end else begin : g_neg
            assign y = (x == TR_NEG) ? a : b;
        end
    endgenerate
endmodule

// File: rtl/tern_half_cell.sv
module tern_half_cell
    import tern_pkg::*;
(
    input  trit_t data_i,
    input  trit_t adj_i,
    output trit_t res_o,
    output trit_t cy_o
);
    trit_t dn_mod;
    trit_t up_mod;
    trit_t lo_edge;
    trit_t hi_edge;

    tern_sel3 u_dn (.sel(data_i), .on_neg(TR_POS), .on_zero(TR_NEG), .on_pos(TR_ZERO), .y(dn_mod));
    tern_sel3 u_up (.sel(data_i), .on_neg(TR_ZERO), .on_zero(TR_POS), .on_pos(TR_NEG), .y(up_mod));
    tern_sel3 u_res (.sel(adj_i), .on_neg(dn_mod), .on_zero(data_i), .on_pos(up_mod), .y(res_o));

    tern_edge #(.POS_SIDE(1'b0)) u_lo (.x(data_i), .a(TR_NEG), .b(TR_ZERO), .y(lo_edge));
    tern_edge #(.POS_SIDE(1'b1)) u_hi (.x(data_i), .a(TR_ZERO), .b(TR_POS), .y(hi_edge));
    tern_sel3 u_cy (.sel(adj_i), .on_neg(lo_edge), .on_zero(TR_ZERO), .on_pos(hi_edge), .y(cy_o));
endmodule

// File: rtl/tern_incdec.sv
module tern_incdec
    import tern_pkg::*;
#(
    parameter int WIDTH = 3
)(
    input  logic [2*WIDTH-1:0] num_i,
    input  logic [1:0]         adj_i,
    output logic [2*WIDTH-1:0] sum_o,
    output logic [1:0]         carry_o
);
    trit_t chain [WIDTH+1];

    assign chain[0] = adj_i;

    generate
        for (genvar k = 0; k < WIDTH; k++) begin : g_cell
            tern_half_cell u_cell (
                .data_i (num_i[2*k +: 2]),
                .adj_i  (chain[k]),
                .res_o  (sum_o[2*k +: 2]),
                .cy_o   (chain[k+1])
            );
        end
    endgenerate

    assign carry_o = chain[WIDTH];
endmodule

// File: rtl/tern_incdec_chk.sv
module tern_incdec_chk
    import tern_pkg::*;
#(
    parameter int WIDTH = 3
)(
    input logic [2*WIDTH-1:0] num_i,
    input logic [1:0]         adj_i,
    input logic [2*WIDTH-1:0] sum_o,
    input logic [1:0]         carry_o
);
    localparam int SPAN = pow3(WIDTH);

    int  v_in;
    int  v_out;
    bit  in_ok;
    bit  out_ok;
    bit  all_p;
    bit  all_n;
    bit  res_all_p;
    bit  res_all_n;

    always_comb begin
        v_in = 0; v_out = 0; in_ok = trit_legal(adj_i); out_ok = trit_legal(carry_o);
        all_p = 1'b1; all_n = 1'b1; res_all_p = 1'b1; res_all_n = 1'b1;
        for (int k = WIDTH - 1; k >= 0; k--) begin
            v_in  = v_in * 3 + trit_val(num_i[2*k +: 2]);
            v_out = v_out * 3 + trit_val(sum_o[2*k +: 2]);
            in_ok  = in_ok && trit_legal(num_i[2*k +: 2]);
            out_ok = out_ok && trit_legal(sum_o[2*k +: 2]);
            all_p = all_p && (num_i[2*k +: 2] == TR_POS);
            all_n = all_n && (num_i[2*k +: 2] == TR_NEG);
            res_all_p = res_all_p && (sum_o[2*k +: 2] == TR_POS);
            res_all_n = res_all_n && (sum_o[2*k +: 2] == TR_NEG);
        end
    end

    always_comb begin
        if (in_ok) begin
            AST_HOLD_PASSTHRU: assert ((adj_i != TR_ZERO) || (sum_o == num_i && carry_o == TR_ZERO)); // R2
            AST_EXACT_SUM: assert (trit_val(carry_o) * SPAN + v_out == v_in + trit_val(adj_i)); // R5
            AST_CARRY_UP: assert ((carry_o != TR_POS) || (all_p && adj_i == TR_POS && res_all_n)); // R6
            AST_CARRY_DOWN: assert ((carry_o != TR_NEG) || (all_n && adj_i == TR_NEG && res_all_p)); // R7
            AST_LEGAL_OUT: assert (out_ok); // R8
        end
    end
endmodule

bind tern_incdec tern_incdec_chk #(.WIDTH(WIDTH)) u_chk (
    .num_i   (num_i),
    .adj_i   (adj_i),
    .sum_o   (sum_o),
    .carry_o (carry_o)
);

// File: tb/tern_incdec_tb.sv
module tern_incdec_tb;
    localparam int W    = 3;
    localparam int SPAN = 27;
    localparam int HALF = 13;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [2*W-1:0] num;
    logic [1:0]     adj;
    logic [2*W-1:0] sum;
    logic [1:0]     cy;
    int             n_chk = 0;
    int             n_bad = 0;
    bit             done  = 1'b0;

    always #2 clk = ~clk;

    tern_incdec #(.WIDTH(W)) u_dut (.num_i(num), .adj_i(adj), .sum_o(sum), .carry_o(cy));

    function automatic logic [1:0] enc1(input int d);
        return (d > 0) ? 2'b01 : (d < 0) ? 2'b11 : 2'b00;
    endfunction

    function automatic logic [2*W-1:0] enc(input int v);
        logic [2*W-1:0] r;
        int x, d;
        x = v; r = '0;
        for (int k = 0; k < W; k++) begin
            d = ((x % 3) + 3) % 3;
            if (d == 2) d = -1;
            r[2*k +: 2] = enc1(d);
            x = (x - d) / 3;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit legal_vec(input logic [2*W-1:0] v, input logic [1:0] c);
        bit ok;
        ok = (c != 2'b10);
        for (int k = 0; k < W; k++) ok = ok && (v[2*k +: 2] != 2'b10);
        return ok;
    endfunction

    initial begin
        num = '0; adj = 2'b00;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 R2: zero operand, hold -> zero result, no carry
        check(sum == '0 && cy == 2'b00, "R2 reset/zero", int'(sum), 0);
        for (int a = -1; a <= 1; a++) begin
            for (int v = -HALF; v <= HALF; v++) begin
                int tot, ev, ec;
                string tg;
                tot = v + a;
                ev  = ((tot + HALF + SPAN) % SPAN) - HALF;
                ec  = (tot - ev) / SPAN;
                @(posedge clk);
                num = enc(v); adj = enc1(a);
                @(negedge clk);
                tg = (a == 0) ? "R2" : (a > 0) ? "R3" : "R4";
                check(sum == enc(ev), {tg, " R1 result"}, int'(sum), int'(enc(ev)));
                check(cy == enc1(ec), "R5 carry", int'(cy), int'(enc1(ec)));
                check(legal_vec(sum, cy), "R8 legal codes", int'(sum), int'(enc(ev)));
                if (v == HALF && a == 1) begin
                    check(cy == 2'b01 && sum == {W{2'b11}}, "R6 wrap up", int'(sum), int'({W{2'b11}}));
                end
                if (v == -HALF && a == -1) begin
                    check(cy == 2'b11 && sum == {W{2'b01}}, "R7 wrap down", int'(sum), int'({W{2'b01}}));
                end
                if (!(v == HALF && a == 1)) check(cy != 2'b01, "R6 no spurious carry", int'(cy), 0);
                if (!(v == -HALF && a == -1)) check(cy != 2'b11, "R7 no spurious borrow", int'(cy), 0);
            end
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R5 watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule